// File: doc/BRIEF.md
# NAND Flash Page Program Sequencer

This block programs one page of a NAND flash device, or a group of devices that share one control bus, over an 8-bit interface. A single start pulse with a block number and a page number begins a fixed sequence. The block chip-selects the device and sends the load command and five address cycles. It then streams the whole page, data area plus spare area, out of a page buffer that the block addresses itself. Next it sends the program-confirm command and waits out the device's busy period. Last, it reads the status byte and reports pass or fail with a one-clock done pulse.

Every interface delay is a whole number of system clock cycles set by a parameter. These are the write-strobe low and high times, the gap between the final address cycle and the first data cycle, the wait before busy is sampled, the gap before the status read, and the chip-select setup. The data bus is split into an output, an output enable and an input, so that the pads can be tristated outside the block.

Top module: `nand_page_program`

## Requirements
- R1: After reset, and while idle, ceN, weN and reN are 1, cle, ale, dqOe, done, busy and fail are 0.
- R2: One operation puts these bytes on dqOut, each latched on a rising weN, in this order. First 0x80 with cle=1. Then five bytes with ale=1: 0x00, 0x00, row[7:0], row[15:8] and {5'b0,row[18:16]}, where row = {blockAddr, pageAddr} and pageAddr fills the 6 low bits. Then PAGE_BYTES (default 2112) bytes with cle=ale=0. Then 0x10 with cle=1. cle and ale are never 1 together.
- R3: Every write strobe holds weN low for exactly WE_LOW clocks (default 4) and high for at least WE_HIGH clocks (default 3) before the next fall. dqOut, cle and ale stay stable while weN is low.
- R4: At least ADL_CYC clocks (default 19) pass between the weN rise of the last address cycle and the weN fall of the first data cycle.
- R5: Data byte i (from 0) is the bufData value returned for bufAddr = i. bufData must be valid one clock after bufAddr changes.
- R6: rbN is ignored for WB_CYC clocks (default 25) after the confirm cycle ends. The status command 0x70 (cle=1) is sent only after rbN has gone low and returned to 1. It is followed by one read strobe (reN low WE_LOW clocks).
- R7: done is a one-clock pulse after the status read. fail equals bit 0 of the status byte that dqIn carries while reN is low. fail holds until the next accepted start.
- R8: dqOe is 1 whenever weN is low and 0 whenever reN is low; weN and reN are never low together.
- R9: A start pulse while busy is 1 is ignored: the running sequence keeps its captured address and gives exactly one done.
- R10: ceN is 0 from before the first command until the done pulse, and returns to 1 one clock after done. While ceN is 1, weN and reN are 1 and dqOe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted when idle |
| blockAddr | input | BLOCK_W | Block to program |
| pageAddr | input | PAGE_W | Page within the block |
| bufAddr | output | clog2(PAGE_BYTES) | Page buffer read address |
| bufData | input | 8 | Page buffer read data, one clock latency |
| ceN | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| weN | output | 1 | Write strobe, active low |
| reN | output | 1 | Read strobe, active low |
| dqOut | output | 8 | Data bus output value |
| dqOe | output | 1 | Data bus output enable (0 = high impedance) |
| dqIn | input | 8 | Data bus input value |
| rbN | input | 1 | Device ready (1) / busy (0) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| fail | output | 1 | Status bit 0 of the last operation |

## Verification
The case hardest to reach is a device that is slow to pull its busy line low after the confirm command. A controller that samples ready too early sees the line still high and reads status before programming has begun. The bench device model lowers rbN only 20 clocks after the confirm strobe rises, inside the protected window. It then holds busy for a randomized length, and it logs whether 0x70 appears after rbN has gone low and come back. A second start pulse injected in the middle of the data stream, with a different address, shows that the captured row bytes and the single done are unaffected.

// File: rtl/nandpp_pkg.sv
package nandpp_pkg;

  typedef enum logic [1:0] {
    SRC_CMD  = 2'd0,
    SRC_ADDR = 2'd1,
    SRC_DATA = 2'd2
  } byteSrcT;

  // strobes from the sequencer to the bus datapath
  typedef struct packed {
    logic       chipSel;
    logic       capture;
    logic       launchWr;
    logic       launchRd;
    logic       cle;
    logic       ale;
    byteSrcT    src;
    logic [7:0] cmdByte;
    logic [2:0] addrIdx;
  } busStrobeT;

  localparam logic [7:0] CMD_LOAD    = 8'h80;
  localparam logic [7:0] CMD_CONFIRM = 8'h10;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam int         ADDR_CYCLES = 5;
  localparam int         COL_CYCLES  = 2;

endpackage

// File: rtl/nandpp_datapath.sv
module nandpp_datapath
  import nandpp_pkg::*;
#(
  parameter int PAGE_BYTES = 2112,
  parameter int BLOCK_W    = 13,
  parameter int PAGE_W     = 6,
  parameter int WE_LOW     = 4,
  parameter int WE_HIGH    = 3,
  localparam int BUF_AW    = $clog2(PAGE_BYTES),
  localparam int BYTE_W    = $clog2(PAGE_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  busStrobeT          strobe,
  input  logic [BLOCK_W-1:0] blockAddr,
  input  logic [PAGE_W-1:0]  pageAddr,
  input  logic [7:0]         bufData,
  input  logic [7:0]         dqIn,
  input  logic               rbN,
  output logic [BUF_AW-1:0]  bufAddr,
  output logic               ceN,
  output logic               cle,
  output logic               ale,
  output logic               weN,
  output logic               reN,
  output logic [7:0]         dqOut,
  output logic               dqOe,
  output logic               busDone,
  output logic               pageLoaded,
  output logic               rdy,
  output logic               statusBit
);

  localparam int CYC_TOTAL  = WE_LOW + WE_HIGH;
  localparam int CNT_W      = (CYC_TOTAL > 1) ? $clog2(CYC_TOTAL) : 1;
  localparam int ROW_W      = BLOCK_W + PAGE_W;
  localparam int ROW_PAD_W  = 8 * (ADDR_CYCLES - COL_CYCLES);
  localparam int ADDR_SLOTS = 8;

  logic [CNT_W-1:0]  cnt;
  logic              active;
  logic              reading;
  logic [BYTE_W-1:0] byteIdx;
  logic [ROW_W-1:0]  rowReg;
  logic [ROW_PAD_W-1:0] rowPad;
  logic [7:0]        addrByte [ADDR_SLOTS];
  logic [7:0]        launchByte;
  logic              rbMeta;
  logic              lowEnd;
  logic              unusedStatusBits;

  assign rowPad = ROW_PAD_W'(rowReg);

  // address byte table: column bytes are zero, row bytes low first
  for (genvar i = 0; i < ADDR_SLOTS; i++) begin : gAddr
    if (i >= COL_CYCLES && i < ADDR_CYCLES) begin : gRow
      assign addrByte[i] = rowPad[8*(i-COL_CYCLES) +: 8];
    end else begin : gZero
      assign addrByte[i] = 8'h00;
    end
  end

  always_comb begin
    case (strobe.src)
      SRC_CMD:  launchByte = strobe.cmdByte;
      SRC_ADDR: launchByte = addrByte[strobe.addrIdx];
      default:  launchByte = bufData;
    endcase
  end

  assign busDone          = active && (cnt == CNT_W'(CYC_TOTAL - 1));
  assign lowEnd           = active && (cnt == CNT_W'(WE_LOW - 1));
  assign pageLoaded       = (byteIdx == BYTE_W'(PAGE_BYTES));
  assign bufAddr          = byteIdx[BUF_AW-1:0];
  assign unusedStatusBits = ^dqIn[7:1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ceN       <= 1'b1;
      weN       <= 1'b1;
      reN       <= 1'b1;
      cle       <= 1'b0;
      ale       <= 1'b0;
      dqOe      <= 1'b0;
      dqOut     <= 8'h00;
      active    <= 1'b0;
      reading   <= 1'b0;
      cnt       <= '0;
      byteIdx   <= '0;
      rowReg    <= '0;
      statusBit <= 1'b0;
      rbMeta    <= 1'b1;
      rdy       <= 1'b1;
    end else begin
      ceN    <= !strobe.chipSel;
      rbMeta <= rbN;
      rdy    <= rbMeta;
      if (strobe.capture) begin
        rowReg  <= {blockAddr, pageAddr};
        byteIdx <= '0;
      end
      if (strobe.launchWr) begin
        active  <= 1'b1;
        reading <= 1'b0;
        cnt     <= '0;
        weN     <= 1'b0;
        cle     <= strobe.cle;
        ale     <= strobe.ale;
        dqOe    <= 1'b1;
        dqOut   <= launchByte;
        if (strobe.src == SRC_DATA) byteIdx <= byteIdx + BYTE_W'(1);
      end else if (strobe.launchRd) begin
        active  <= 1'b1;
        reading <= 1'b1;
        cnt     <= '0;
        reN     <= 1'b0;
        cle     <= 1'b0;
        ale     <= 1'b0;
        dqOe    <= 1'b0;
      end else if (active) begin
        cnt <= cnt + CNT_W'(1);
        if (lowEnd) begin
          weN <= 1'b1;
          reN <= 1'b1;
          if (reading) statusBit <= dqIn[0];
        end
        if (busDone) begin
          active <= 1'b0;
          cle    <= 1'b0;
          ale    <= 1'b0;
          dqOe   <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/nandpp_ctrl.sv
module nandpp_ctrl
  import nandpp_pkg::*;
#(
  parameter int ADL_CYC = 19,
  parameter int WB_CYC  = 25,
  parameter int WHR_CYC = 15,
  parameter int CS_CYC  = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      busDone,
  input  logic      pageLoaded,
  input  logic      rdy,
  input  logic      statusBit,
  output busStrobeT strobe,
  output logic      busy,
  output logic      done,
  output logic      fail
);

  localparam int MAX_AB = (ADL_CYC > WB_CYC) ? ADL_CYC : WB_CYC;
  localparam int MAX_WC = (WHR_CYC > CS_CYC) ? WHR_CYC : CS_CYC;
  localparam int MAX_W  = (MAX_AB > MAX_WC) ? MAX_AB : MAX_WC;
  localparam int WAIT_W = $clog2(MAX_W + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CE, S_CMD1, S_ADDR, S_ADL, S_DATA, S_CONF,
    S_WB, S_RDY, S_SCMD, S_WHR, S_SREAD
  } stateT;

  stateT             state, nextState;
  logic [WAIT_W-1:0] waitCnt;
  logic [2:0]        addrSel;
  logic              finish;

  function automatic logic waitHit(input logic [WAIT_W-1:0] c, input int n);
    return c == WAIT_W'(n - 1);
  endfunction

  always_comb begin
    strobe         = '0;
    strobe.chipSel = (state != S_IDLE);
    strobe.src     = SRC_CMD;
    nextState      = state;
    finish         = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        strobe.capture = 1'b1;
        nextState      = S_CE;
      end
      S_CE: if (waitHit(waitCnt, CS_CYC)) begin
        strobe.launchWr = 1'b1;
        strobe.cle      = 1'b1;
        strobe.cmdByte  = CMD_LOAD;
        nextState       = S_CMD1;
      end
      S_CMD1: if (busDone) begin
        strobe.launchWr = 1'b1;
        strobe.ale      = 1'b1;
        strobe.src      = SRC_ADDR;
        strobe.addrIdx  = 3'd0;
        nextState       = S_ADDR;
      end
      S_ADDR: if (busDone) begin
        if (addrSel == 3'(ADDR_CYCLES - 1)) begin
          nextState = S_ADL;
        end else begin
          strobe.launchWr = 1'b1;
          strobe.ale      = 1'b1;
          strobe.src      = SRC_ADDR;
          strobe.addrIdx  = addrSel + 3'd1;
        end
      end
      S_ADL: if (waitHit(waitCnt, ADL_CYC)) begin
        strobe.launchWr = 1'b1;
        strobe.src      = SRC_DATA;
        nextState       = S_DATA;
      end
      S_DATA: if (busDone) begin
        strobe.launchWr = 1'b1;
        if (pageLoaded) begin
          strobe.cle     = 1'b1;
          strobe.cmdByte = CMD_CONFIRM;
          nextState      = S_CONF;
        end else begin
          strobe.src = SRC_DATA;
        end
      end
      S_CONF: if (busDone) nextState = S_WB;
      S_WB:   if (waitHit(waitCnt, WB_CYC)) nextState = S_RDY;
      S_RDY: if (rdy) begin
        strobe.launchWr = 1'b1;
        strobe.cle      = 1'b1;
        strobe.cmdByte  = CMD_STATUS;
        nextState       = S_SCMD;
      end
      S_SCMD: if (busDone) nextState = S_WHR;
      S_WHR: if (waitHit(waitCnt, WHR_CYC)) begin
        strobe.launchRd = 1'b1;
        nextState       = S_SREAD;
      end
      S_SREAD: if (busDone) begin
        finish    = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waitCnt <= '0;
      addrSel <= 3'd0;
      done    <= 1'b0;
      fail    <= 1'b0;
    end else begin
      state   <= nextState;
      waitCnt <= (nextState != state) ? '0 : waitCnt + WAIT_W'(1);
      if (strobe.launchWr && strobe.src == SRC_ADDR) addrSel <= strobe.addrIdx;
      done <= finish;
      if (strobe.capture)  fail <= 1'b0;
      else if (finish)     fail <= statusBit;
    end
  end

endmodule

// File: rtl/nand_page_program.sv
module nand_page_program
  import nandpp_pkg::*;
#(
  parameter int PAGE_BYTES = 2112,
  parameter int BLOCK_W    = 13,
  parameter int PAGE_W     = 6,
  parameter int WE_LOW     = 4,
  parameter int WE_HIGH    = 3,
  parameter int ADL_CYC    = 19,
  parameter int WB_CYC     = 25,
  parameter int WHR_CYC    = 15,
  parameter int CS_CYC     = 2,
  localparam int BUF_AW    = $clog2(PAGE_BYTES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [BLOCK_W-1:0] blockAddr,
  input  logic [PAGE_W-1:0]  pageAddr,
  output logic [BUF_AW-1:0]  bufAddr,
  input  logic [7:0]         bufData,
  output logic               ceN,
  output logic               cle,
  output logic               ale,
  output logic               weN,
  output logic               reN,
  output logic [7:0]         dqOut,
  output logic               dqOe,
  input  logic [7:0]         dqIn,
  input  logic               rbN,
  output logic               busy,
  output logic               done,
  output logic               fail
);

  busStrobeT strobe;
  logic      busDone;
  logic      pageLoaded;
  logic      rdy;
  logic      statusBit;

  nandpp_ctrl #(
    .ADL_CYC(ADL_CYC), .WB_CYC(WB_CYC), .WHR_CYC(WHR_CYC), .CS_CYC(CS_CYC)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .busDone(busDone),
    .pageLoaded(pageLoaded), .rdy(rdy), .statusBit(statusBit),
    .strobe(strobe), .busy(busy), .done(done), .fail(fail)
  );

  nandpp_datapath #(
    .PAGE_BYTES(PAGE_BYTES), .BLOCK_W(BLOCK_W), .PAGE_W(PAGE_W),
    .WE_LOW(WE_LOW), .WE_HIGH(WE_HIGH)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .blockAddr(blockAddr),
    .pageAddr(pageAddr), .bufData(bufData), .dqIn(dqIn), .rbN(rbN),
    .bufAddr(bufAddr), .ceN(ceN), .cle(cle), .ale(ale), .weN(weN),
    .reN(reN), .dqOut(dqOut), .dqOe(dqOe), .busDone(busDone),
    .pageLoaded(pageLoaded), .rdy(rdy), .statusBit(statusBit)
  );

endmodule

// File: rtl/nand_page_program_chk.sv
module nand_page_program_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ceN,
  input logic       cle,
  input logic       ale,
  input logic       weN,
  input logic       reN,
  input logic [7:0] dqOut,
  input logic       dqOe,
  input logic       rbN,
  input logic       busy,
  input logic       done
);

  assert_lane_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    cle |-> !ale);

  assert_hold_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!weN && $past(!weN)) |-> ($stable(dqOut) && $stable(cle) && $stable(ale)));

  assert_read_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    !reN |-> rbN);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> reN);

  assert_drive_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> dqOe);

  assert_float_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    !reN |-> !dqOe);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_ce_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    ceN |-> (weN && reN && !dqOe));

endmodule

bind nand_page_program nand_page_program_chk uChk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .cle(cle), .ale(ale), .weN(weN),
  .reN(reN), .dqOut(dqOut), .dqOe(dqOe), .rbN(rbN), .busy(busy), .done(done)
);

// File: tb/tb_nand_page_program.sv
`timescale 1ns/1ps
module tb_nand_page_program;

  localparam int PAGE_BYTES = 2112;
  localparam int BLOCK_W    = 13;
  localparam int PAGE_W     = 6;
  localparam int WE_LOW     = 4;
  localparam int WE_HIGH    = 3;
  localparam int ADL_CYC    = 19;
  localparam int WB_CYC     = 25;
  localparam int BUF_AW     = $clog2(PAGE_BYTES);
  localparam int LOGN       = PAGE_BYTES + 16;
  localparam int RB_DELAY   = 20;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               start = 1'b0;
  logic [BLOCK_W-1:0] blockAddr = '0;
  logic [PAGE_W-1:0]  pageAddr = '0;
  logic [BUF_AW-1:0]  bufAddr;
  logic [7:0]         bufData = 8'h00;
  logic               ceN, cle, ale, weN, reN, dqOe, busy, done, fail;
  logic [7:0]         dqOut;
  logic [7:0]         dqIn;
  logic               rbN = 1'b1;
  logic [7:0]         statusVal = 8'hE0;

  always #2 clk = ~clk;

  nand_page_program dut (
    .clk(clk), .rstN(rstN), .start(start), .blockAddr(blockAddr),
    .pageAddr(pageAddr), .bufAddr(bufAddr), .bufData(bufData), .ceN(ceN),
    .cle(cle), .ale(ale), .weN(weN), .reN(reN), .dqOut(dqOut), .dqOe(dqOe),
    .dqIn(dqIn), .rbN(rbN), .busy(busy), .done(done), .fail(fail)
  );

  // status is valid only while the read strobe is low
  assign dqIn = reN ? ~statusVal : statusVal;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int salt = 0;

  function automatic logic [7:0] bufByte(input int s, input int i);
    return 8'((i * 37) ^ (s * 11) ^ (i >> 3));
  endfunction

  always @(posedge clk) bufData <= bufByte(salt, int'(bufAddr));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bus monitor and device model
  logic [7:0] logByte [LOGN];
  int  logKind [LOGN];
  int  logIdx = 0;
  int  cyc = 0;
  bit  prevWe = 1, prevRe = 1;
  int  lowCnt = 0, highCnt = 0, paceErr = 0;
  int  lastAddrRise = 0, adlGap = -1;
  bit  confSeen = 0;
  int  sinceConf = 0;
  int  busyLen = 100;
  bit  rbFell = 0, rbRose = 0;
  int  rbRiseCyc = 0;
  int  statCmdCyc = -1;
  bit  statAfterRb = 0;
  int  readCnt = 0;
  int  ceErr = 0;
  bit  opActive = 0;

  always @(negedge clk) begin
    cyc++;
    if (prevWe && !weN) begin
      if (logIdx > 0 && highCnt < WE_HIGH) paceErr++;
      if (!cle && !ale && logIdx > 0 && logKind[logIdx-1] == 1)
        adlGap = cyc - lastAddrRise;
      lowCnt = 0;
    end
    if (!prevWe && weN) begin
      if (lowCnt != WE_LOW) paceErr++;
      highCnt = 0;
      if (logIdx < LOGN) begin
        logByte[logIdx] = dqOut;
        logKind[logIdx] = cle ? 0 : (ale ? 1 : 2);
        logIdx++;
      end
      if (ale) lastAddrRise = cyc;
      if (cle && dqOut == 8'h10) begin
        confSeen = 1;
        sinceConf = 0;
      end
      if (cle && dqOut == 8'h70) begin
        statCmdCyc = cyc;
        statAfterRb = rbFell && rbRose;
      end
    end
    if (prevRe && !reN) readCnt++;
    if (!weN) lowCnt++; else highCnt++;
    if (opActive && logIdx > 0 && ceN) ceErr++;
    if (confSeen) begin
      sinceConf++;
      if (sinceConf == RB_DELAY) begin
        rbN <= 1'b0;
        rbFell = 1;
      end
      if (sinceConf == RB_DELAY + busyLen) begin
        rbN <= 1'b1;
        rbRose = 1;
        rbRiseCyc = cyc;
        confSeen = 0;
      end
    end
    prevWe = weN;
    prevRe = reN;
  end

  task automatic runOp(input int blk, input int pg, input int bLen, input bit failBit,
                       input bit extraStart);
    int row;
    int dataErr;
    int doneCnt;
    bit gotDone;
    row = (blk << PAGE_W) | pg;
    salt = blk * 3 + pg + 1;
    busyLen = bLen;
    statusVal = 8'hE0 | {7'b0, failBit};
    logIdx = 0; paceErr = 0; adlGap = -1; rbFell = 0; rbRose = 0;
    statCmdCyc = -1; statAfterRb = 0; readCnt = 0; ceErr = 0; doneCnt = 0;
    @(posedge clk); #1;
    start = 1'b1;
    blockAddr = BLOCK_W'(blk);
    pageAddr = PAGE_W'(pg);
    opActive = 1;
    @(posedge clk); #1;
    start = 1'b0;
    blockAddr = ~BLOCK_W'(blk);
    pageAddr = ~PAGE_W'(pg);
    @(negedge clk);
    chk(busy == 1'b1, "R9 busy after start", busy, 1);
    if (extraStart) begin
      repeat (800) @(posedge clk);
      #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    gotDone = 0;
    for (int k = 0; k < 60000 && !gotDone; k++) begin
      @(negedge clk);
      if (done) gotDone = 1;
    end
    chk(gotDone, "R7 done reached", gotDone, 1);
    doneCnt = gotDone ? 1 : 0;
    chk(fail == failBit, "R7 fail equals status bit0", fail, failBit);
    chk(busy == 1'b0, "R9 idle at done", busy, 0);
    opActive = 0;
    @(negedge clk);
    chk(done == 1'b0, "R7 done is one clock", done, 0);
    chk(ceN == 1'b1, "R10 ceN high after done", ceN, 1);
    repeat (40) begin
      @(negedge clk);
      if (done) doneCnt++;
    end
    chk(doneCnt == 1, "R9 single done", doneCnt, 1);
    chk(fail == failBit, "R7 fail held", fail, failBit);
    chk(ceErr == 0, "R10 ceN low during op", ceErr, 0);
    chk(logIdx == PAGE_BYTES + 8, "R2 byte count", logIdx, PAGE_BYTES + 8);
    chk(logByte[0] == 8'h80 && logKind[0] == 0, "R2 load command", logByte[0], 128);
    chk(logByte[1] == 8'h00 && logByte[2] == 8'h00 && logKind[1] == 1 && logKind[2] == 1,
        "R2 column bytes", {logByte[1], logByte[2]}, 0);
    chk(logByte[3] == 8'(row) && logKind[3] == 1, "R2 row byte0", logByte[3], 8'(row));
    chk(logByte[4] == 8'(row >> 8) && logKind[4] == 1, "R2 row byte1", logByte[4], 8'(row >> 8));
    chk(logByte[5] == 8'(row >> 16) && logKind[5] == 1, "R2 row byte2", logByte[5], 8'(row >> 16));
    dataErr = 0;
    for (int i = 0; i < PAGE_BYTES; i++)
      if (logByte[6+i] != bufByte(salt, i) || logKind[6+i] != 2) dataErr++;
    chk(dataErr == 0, "R5 data bytes", dataErr, 0);
    chk(logByte[6+PAGE_BYTES] == 8'h10 && logKind[6+PAGE_BYTES] == 0, "R2 confirm command",
        logByte[6+PAGE_BYTES], 16);
    chk(logByte[7+PAGE_BYTES] == 8'h70, "R6 status command", logByte[7+PAGE_BYTES], 112);
    chk(paceErr == 0, "R3 strobe pacing", paceErr, 0);
    chk(adlGap >= ADL_CYC, "R4 address to data gap", adlGap, ADL_CYC);
    chk(statAfterRb && statCmdCyc > rbRiseCyc, "R6 status after ready", statCmdCyc, rbRiseCyc);
    chk(readCnt == 1, "R6 single status read", readCnt, 1);
  endtask

  initial begin
    int seedInit;
    seedInit = $urandom(20240607);
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(ceN && weN && reN, "R1 strobes idle high", {ceN, weN, reN}, 7);
    chk(!cle && !ale && !dqOe, "R1 latches and drive low", {cle, ale, dqOe}, 0);
    chk(!done && !busy && !fail, "R1 flags low", {done, busy, fail}, 0);
    runOp(0, 0, 300, 1'b0, 1'b0);
    runOp(8191, 63, 150, 1'b1, 1'b1);
    chk(!cle && !ale && !dqOe && weN, "R1 idle between ops", {cle, ale, dqOe}, 0);
    for (int n = 0; n < 3; n++) begin
      int b, p, l;
      bit f;
      b = int'($urandom_range(0, 8191));
      p = int'($urandom_range(0, 63));
      l = int'($urandom_range(60, 1200));
      f = 1'($urandom_range(0, 1));
      runOp(b, p, l, f, 1'b0);
    end
    runOp(1, 0, 300, 1'b0, 1'b0);
    chk(fail == 1'b0, "R7 fail cleared by new start", fail, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule